// File: doc/BRIEF.md
# ADC Engine Clock Request and Prescaler Controller

This block governs the clocking of an analog-to-digital converter engine. It runs on the selected engine clock: the peripheral bus clock when synchronous mode is chosen, or a clock from the clock unit when asynchronous mode is chosen. The clock mux itself is outside the block. In asynchronous mode the block asks the clock unit for the clock. It does so either all the time or only for the length of one conversion, as a policy field and a warm-mode field select.

Once the clock is live, the block counts a warmup interval in undivided engine-clock cycles. A conversion trigger that arrives before warmup has ended is held, and the conversion starts as soon as warmup completes. The block also divides the engine clock by a programmable factor from 1 to 128. The result is a one-cycle enable pulse that paces conversion and acquisition timing.

Encodings: `async_mode` = 1 selects asynchronous mode. `req_on_demand` = 1 selects the per-conversion request policy. `keep_warm` = 1 selects the keep-warm mode and `keep_warm` = 0 the normal warm mode. `presc` = N divides by N+1. The clock is "live" when `async_mode` = 0, or when `clk_req` and `clk_ack` are both high. Reset is synchronous and active low.

Top module: `adc_clk_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `clk_req`, `sar_en`, `warm_done` and `conv_start` are all 0 after that edge, whatever the other inputs are.
- R2: With `async_mode` = 0, `clk_req` is 0 after every edge, whatever `trig`, `conv_done`, `req_on_demand` and `keep_warm` do.
- R3: With `async_mode` = 1, `req_on_demand` = 1 and `keep_warm` = 0, `clk_req` stays 0 while no conversion is pending or running. It rises at the edge that samples `trig`.
- R4: In that on-demand combination, `clk_req` stays high for as long as a conversion is pending or running. It falls at the edge that samples `conv_done` during a running conversion.
- R5: With `async_mode` = 1 and any other `req_on_demand`/`keep_warm` combination, `clk_req` is 1 after every edge, whatever `trig` and `conv_done` do.
- R6: `warm_done` goes high after exactly WARM_CYCLES consecutive edges at which the clock is live. It returns to 0 after the first edge at which the clock is not live.
- R7: A trigger accepted while `warm_done` is 0 is held. `conv_start` then pulses for one cycle after the first edge that sees `warm_done` high. If `warm_done` is already high, `conv_start` pulses after the very edge that samples `trig`.
- R8: `trig` is ignored while a conversion is pending or running, including when it arrives in the same cycle as `conv_done`. `conv_done` is ignored while no conversion is running.
- R9: While the clock is live, `sar_en` pulses once every `presc`+1 edges. The first pulse comes after the (`presc`+1)th live edge, so `presc` = 0 gives a pulse every cycle and `presc` = 127 gives one every 128 cycles.
- R10: After any edge at which the clock is not live, `sar_en` is 0, and the division count restarts from zero.
- R11: Asserting `rst_n` in the middle of operation clears the request, the warmup state and the prescaler at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Selected engine clock |
| rst_n | input | 1 | Synchronous reset, active low |
| async_mode | input | 1 | 1 = asynchronous engine clock, 0 = bus clock |
| req_on_demand | input | 1 | 1 = request the clock per conversion |
| keep_warm | input | 1 | 1 = keep-warm mode, 0 = normal warm mode |
| presc | input | PRESC_W | Division factor minus one |
| trig | input | 1 | Conversion trigger |
| conv_done | input | 1 | Conversion complete indication |
| clk_ack | input | 1 | Clock unit reports the asynchronous clock ready |
| clk_req | output | 1 | Request for the asynchronous clock |
| sar_en | output | 1 | One-cycle conversion-clock enable |
| warm_done | output | 1 | Warmup interval complete |
| conv_start | output | 1 | One-cycle pulse when a conversion begins |

## Verification
In on-demand mode, a fresh trigger can reach the block in the same cycle as the completion of the running conversion. The bench drives `trig` and `conv_done` together during a running conversion. It expects `clk_req` to fall at that edge and to stay low on the following edges with no `conv_start`, which shows that the trigger was dropped. A second collision is the end of warmup in the same cycle as a pending start. The bench checks that `warm_done` and `conv_start` appear one edge apart, each at its computed edge, while `sar_en` keeps its own cadence.

// File: rtl/adc_clk_pkg.sv
// Package: shared types for the ADC clock controller.
// Assumes nothing beyond standard SystemVerilog.
package adc_clk_pkg;

    // Conversion tracking states.
    typedef enum logic [1:0] {
        CONV_IDLE = 2'd0,
        CONV_PEND = 2'd1,
        CONV_BUSY = 2'd2
    } conv_state_e;

endpackage

// File: rtl/adc_clk_req_ctrl.sv
// Module: adc_clk_req_ctrl
// Tracks conversions (idle, pending on warmup, running) and drives the
// asynchronous clock request according to the mode and policy fields.
// Assumes all inputs are synchronous to clk.
module adc_clk_req_ctrl
    import adc_clk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic async_mode,
    input  logic req_on_demand,
    input  logic keep_warm,
    input  logic trig,
    input  logic conv_done,
    input  logic warm_done,
    output logic clk_req,
    output logic conv_start
);

    conv_state_e state_q;
    conv_state_e state_d;
    logic        on_demand;

    // Per-conversion request policy applies only in this one combination.
    assign on_demand = async_mode & req_on_demand & ~keep_warm;

    // Next conversion state: accept a trigger only when idle, finish on done.
    always_comb begin
        state_d = state_q;
        case (state_q)
            CONV_IDLE: if (trig)      state_d = warm_done ? CONV_BUSY : CONV_PEND;
            CONV_PEND: if (warm_done) state_d = CONV_BUSY;
            CONV_BUSY: if (conv_done) state_d = CONV_IDLE;
            default:                  state_d = CONV_IDLE;
        endcase
    end

    // Register the state, the request and the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= CONV_IDLE;
            clk_req    <= 1'b0;
            conv_start <= 1'b0;
        end else begin
            state_q    <= state_d;
            clk_req    <= async_mode & (~on_demand | (state_d != CONV_IDLE));
            conv_start <= (state_d == CONV_BUSY) && (state_q != CONV_BUSY);
        end
    end

endmodule

// File: rtl/adc_clk_warmup.sv
// Module: adc_clk_warmup
// Counts undivided engine-clock cycles while the clock is live and flags
// warmup completion after WARM_CYCLES of them. Losing the clock restarts it.
// Assumes live is synchronous to clk.
module adc_clk_warmup #(
    parameter int WARM_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    output logic warm_done
);

    generate
        if (WARM_CYCLES == 0) begin : g_nowarm
            logic live_q;

            // Without a warmup interval, report ready one edge after going live.
            always_ff @(posedge clk) begin
                if (!rst_n) live_q <= 1'b0;
                else        live_q <= live;
            end
            assign warm_done = live_q;
        end else begin : g_warm
            localparam int WARM_W = $clog2(WARM_CYCLES + 1);
            localparam logic [WARM_W-1:0] WARM_LIM = WARM_W'(WARM_CYCLES);
            logic [WARM_W-1:0] cnt_q;

            // Count up to the limit while live; clear when the clock goes away.
            always_ff @(posedge clk) begin
                if (!rst_n || !live) cnt_q <= '0;
                else if (cnt_q != WARM_LIM) cnt_q <= cnt_q + 1'b1;
            end
            assign warm_done = (cnt_q == WARM_LIM);
        end
    endgenerate

endmodule

// File: rtl/adc_clk_presc.sv
// Module: adc_clk_presc
// Divides the engine clock by presc+1, producing a one-cycle enable pulse.
// Assumes presc may change at any time; an out-of-range count wraps at once.
module adc_clk_presc #(
    parameter int PRESC_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               live,
    input  logic [PRESC_W-1:0] presc,
    output logic               sar_en
);

    logic [PRESC_W-1:0] cnt_q;

    // Advance the divider while live and emit a pulse on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !live) begin
            cnt_q  <= '0;
            sar_en <= 1'b0;
        end else if (cnt_q >= presc) begin
            cnt_q  <= '0;
            sar_en <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            sar_en <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_clk_ctrl.sv
// Module: adc_clk_ctrl (top)
// Clock request, warmup and prescaler control for an ADC engine.
// Assumes clk is the already-selected engine clock and that clk_ack comes
// from the clock unit synchronised to clk.
module adc_clk_ctrl #(
    parameter int PRESC_W     = 7,
    parameter int WARM_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               async_mode,
    input  logic               req_on_demand,
    input  logic               keep_warm,
    input  logic [PRESC_W-1:0] presc,
    input  logic               trig,
    input  logic               conv_done,
    input  logic               clk_ack,
    output logic               clk_req,
    output logic               sar_en,
    output logic               warm_done,
    output logic               conv_start
);

    logic live;

    // The engine clock is usable in sync mode, or when requested and acknowledged.
    assign live = ~async_mode | (clk_req & clk_ack);

    adc_clk_req_ctrl u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .async_mode   (async_mode),
        .req_on_demand(req_on_demand),
        .keep_warm    (keep_warm),
        .trig         (trig),
        .conv_done    (conv_done),
        .warm_done    (warm_done),
        .clk_req      (clk_req),
        .conv_start   (conv_start)
    );

    adc_clk_warmup #(.WARM_CYCLES(WARM_CYCLES)) u_warm (
        .clk      (clk),
        .rst_n    (rst_n),
        .live     (live),
        .warm_done(warm_done)
    );

    adc_clk_presc #(.PRESC_W(PRESC_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .live  (live),
        .presc (presc),
        .sar_en(sar_en)
    );

endmodule

// File: rtl/adc_clk_ctrl_chk.sv
// Module: adc_clk_ctrl_chk
// Port-level properties of adc_clk_ctrl, attached by bind.
module adc_clk_ctrl_chk #(
    parameter int PRESC_W = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               async_mode,
    input logic               req_on_demand,
    input logic               keep_warm,
    input logic [PRESC_W-1:0] presc,
    input logic               trig,
    input logic               conv_done,
    input logic               clk_ack,
    input logic               clk_req,
    input logic               sar_en,
    input logic               warm_done,
    input logic               conv_start
);

    logic on_dem;
    logic clk_live;
    assign on_dem   = async_mode & req_on_demand & ~keep_warm;
    assign clk_live = ~async_mode | (clk_req & clk_ack);

    // R2
    sync_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !async_mode |=> !clk_req);

    // R5
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (async_mode && !on_dem) |=> clk_req);

    // R3
    trig_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_dem && trig && !conv_done) |=> clk_req);

    // R6
    warm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_live |=> !warm_done);

    // R9
    div_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_live && presc == '0) |=> sar_en);

    // R10
    div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_live |=> !sar_en);

    // R7
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

endmodule

bind adc_clk_ctrl adc_clk_ctrl_chk #(.PRESC_W(PRESC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .async_mode   (async_mode),
    .req_on_demand(req_on_demand),
    .keep_warm    (keep_warm),
    .presc        (presc),
    .trig         (trig),
    .conv_done    (conv_done),
    .clk_ack      (clk_ack),
    .clk_req      (clk_req),
    .sar_en       (sar_en),
    .warm_done    (warm_done),
    .conv_start   (conv_start)
);

// File: tb/tb_adc_clk_ctrl.sv
// Directed bench for adc_clk_ctrl: inputs and samples at the falling edge.
module tb_adc_clk_ctrl;

    localparam int PW = 7;
    localparam int WC = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          async_mode, req_on_demand, keep_warm;
    logic [PW-1:0] presc;
    logic          trig, conv_done, clk_ack;
    logic          clk_req, sar_en, warm_done, conv_start;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    adc_clk_ctrl #(.PRESC_W(PW), .WARM_CYCLES(WC)) dut (
        .clk(clk), .rst_n(rst_n), .async_mode(async_mode),
        .req_on_demand(req_on_demand), .keep_warm(keep_warm), .presc(presc),
        .trig(trig), .conv_done(conv_done), .clk_ack(clk_ack),
        .clk_req(clk_req), .sar_en(sar_en), .warm_done(warm_done),
        .conv_start(conv_start)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One rising edge; returns at the following falling edge.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        trig = 1'b0; conv_done = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    // R1: reset state, even with an always-on configuration applied.
    task automatic t_reset();
        async_mode = 1'b1; req_on_demand = 1'b0; keep_warm = 1'b0;
        clk_ack = 1'b1; presc = '0; trig = 1'b1; conv_done = 1'b0;
        rst_n = 1'b0;
        repeat (3) step();
        check("R1 clk_req", clk_req, 0);
        check("R1 sar_en", sar_en, 0);
        check("R1 warm_done", warm_done, 0);
        check("R1 conv_start", conv_start, 0);
        trig = 1'b0;
    endtask

    // R2, R6, R7, R8, R9 in synchronous mode.
    task automatic t_sync();
        int bad_req = 0, bad_en = 0;
        async_mode = 1'b0; req_on_demand = 1'b1; keep_warm = 1'b0;
        clk_ack = 1'b0; presc = '0;
        do_reset();
        for (int k = 1; k <= WC; k++) begin
            step();
            if (k == WC - 1) check("R6 warm before limit", warm_done, 0);
            if (k == WC)     check("R6 warm at limit", warm_done, 1);
            if (clk_req) bad_req++;
            if (!sar_en) bad_en++;
        end
        check("R2 no request in sync", bad_req, 0);
        check("R9 div-by-1 every cycle", bad_en, 0);
        trig = 1'b1; step();
        check("R7 immediate start", conv_start, 1);
        check("R2 no request on trigger", clk_req, 0);
        step();
        check("R8 trigger while running", conv_start, 0);
        trig = 1'b0; conv_done = 1'b1; step();
        step();
        conv_done = 1'b0; step();
        check("R8 done while idle", conv_start, 0);
    endtask

    // R3, R4, R6, R7, R8, R9, R10 in on-demand asynchronous mode.
    task automatic t_ondemand();
        int bad_en = 0;
        async_mode = 1'b1; req_on_demand = 1'b1; keep_warm = 1'b0;
        clk_ack = 1'b0; presc = 7'd3;
        do_reset();
        conv_done = 1'b1; step(); step();
        conv_done = 1'b0;
        check("R3 idle no request", clk_req, 0);
        trig = 1'b1; step(); trig = 1'b0;
        check("R3 request on trigger", clk_req, 1);
        repeat (3) step();
        check("R10 no enable without ack", sar_en, 0);
        check("R6 no warmup without ack", warm_done, 0);
        check("R7 trigger held", conv_start, 0);
        clk_ack = 1'b1;
        for (int k = 1; k <= WC; k++) begin
            step();
            if (sar_en != ((k % 4) == 0)) bad_en++;
            if (k == WC - 1) check("R6 async warm before limit", warm_done, 0);
            if (k == WC) begin
                check("R6 async warm at limit", warm_done, 1);
                check("R7 start waits one edge", conv_start, 0);
            end
        end
        check("R9 divide by 4 cadence", bad_en, 0);
        step();
        check("R7 held start", conv_start, 1);
        trig = 1'b1; step(); trig = 1'b0;
        check("R8 no restart while running", conv_start, 0);
        check("R4 request held while running", clk_req, 1);
        trig = 1'b1; conv_done = 1'b1; step();
        trig = 1'b0; conv_done = 1'b0;
        check("R4 request drops at done", clk_req, 0);
        check("R8 collided trigger", conv_start, 0);
        step();
        check("R8 collided trigger lost", clk_req, 0);
        check("R6 warm cleared", warm_done, 0);
        check("R10 enable off", sar_en, 0);
    endtask

    // R5, R9, R2, R3, R11 with the request held on.
    task automatic t_always();
        int pulses = 0, first = 0, bad_req = 0;
        async_mode = 1'b1; req_on_demand = 1'b0; keep_warm = 1'b0;
        clk_ack = 1'b1; presc = 7'd127;
        do_reset();
        for (int k = 1; k <= 260; k++) begin
            step();
            if (!clk_req) bad_req++;
            if (sar_en) begin
                pulses++;
                if (first == 0) first = k;
            end
        end
        check("R5 request held", bad_req, 0);
        check("R9 div-128 first pulse", first, 129);
        check("R9 div-128 pulse count", pulses, 2);
        req_on_demand = 1'b1; keep_warm = 1'b1; step();
        check("R5 keep-warm holds", clk_req, 1);
        trig = 1'b1; step(); trig = 1'b0;
        check("R7 start when warm", conv_start, 1);
        conv_done = 1'b1; step(); conv_done = 1'b0;
        check("R5 held past done", clk_req, 1);
        async_mode = 1'b0; step();
        check("R2 sync drops request", clk_req, 0);
        async_mode = 1'b1; keep_warm = 1'b0; step();
        check("R3 on-demand idle", clk_req, 0);
        keep_warm = 1'b1; repeat (WC + 3) step();
        check("R6 warm again", warm_done, 1);
        rst_n = 1'b0; step();
        check("R11 request cleared", clk_req, 0);
        check("R11 warm cleared", warm_done, 0);
        check("R11 enable cleared", sar_en, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_sync();
        t_ondemand();
        t_always();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule